// File: doc/BRIEF.md
# Daisy-Chain Crosspoint Programming Sequencer

This block is the host-side controller for a string of buffered crosspoint switch devices. The devices share one serial clock, one update strobe and one chip select, and their serial data pins are wired in series. The block takes a routing table for every device in the string: a source index and an output-enable bit for each output, plus one clamp-enable bit per device. From that table it builds one programming frame per device and shifts all of the frames out on a single serial line. It then pulses the shared update strobe low to commit the new routing to every device at once.

At power-up the block first holds the devices' reset line low, with the update strobe high. It then releases reset and waits for a request. A request is a one-cycle `start` pulse while `busy` is low. The table is captured on that cycle. Completion is reported by a one-cycle `done` pulse.

The serial clock is derived from the system clock. Serial data changes only while the serial clock is low, and the clock rises in the middle of each bit.

Top module: `xpt_chain_prog`

## Requirements
- R1: From reset until the RST_HOLD-th rising clock edge after `rst_n` is released, the following hold: `dev_rst_n` is low, `upd_n` and `cs_n` are high, `busy` is high, and a `start` pulse has no effect. `dev_rst_n` goes high on that RST_HOLD-th edge. `upd_n` is never low while `dev_rst_n` is low.
- R2: Each accepted request produces exactly FRAME×NUM_DEV rising edges of `sclk`, where FRAME = 1 + NUM_OUT×(SEL_W+1) + PAD_BITS (193 with the defaults).
- R3: The frame for chain position NUM_DEV-1 (the device farthest from the host) is shifted first, and the frame for position 0 is shifted last. Configuration slot s = d×NUM_OUT + o (device d, output o) holds its source index in `cfg_src[s*SEL_W +: SEL_W]` and its enable in `cfg_en[s]`. The clamp enable of device d is `cfg_clamp[d]`.
- R4: Each frame is shifted in this order: the clamp bit; then, for each output from NUM_OUT-1 down to 0, its enable bit followed by its source index from MSB to LSB; then PAD_BITS zero bits.
- R5: Every bit lasts SCLK_DIV system cycles. `sclk` is low for the first SCLK_DIV/2 cycles of the bit and high for the rest. `sdata` changes only while `sclk` is low, so it is steady around every rising edge of `sclk`.
- R6: `cs_n` goes low on the cycle the first bit is presented. It stays low through the end of the update pulse and is high at all other times. `sclk` is never high while `cs_n` is high.
- R7: `upd_n` stays high while data is shifting. It falls only on the cycle after the last bit period ends, stays low for exactly STROBE_CYC cycles, and `sclk` stays low during that time.
- R8: `done` is high for exactly one cycle, after `upd_n` and `cs_n` have returned high. `busy` falls on the next cycle. One request produces one `done` pulse.
- R9: A `start` pulse that arrives while `busy` is high is ignored. The table captured on the accepted `start` is the one sent, even if the configuration inputs change during shifting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to program the chain |
| cfg_src | input | NUM_DEV×NUM_OUT×SEL_W | Source index of every device output, packed by slot |
| cfg_en | input | NUM_DEV×NUM_OUT | Output enable of every device output, packed by slot |
| cfg_clamp | input | NUM_DEV | Clamp enable per chain position |
| busy | output | 1 | High during power-up sequencing and during a request |
| done | output | 1 | One-cycle completion pulse |
| dev_rst_n | output | 1 | Active-low reset line to the devices |
| cs_n | output | 1 | Active-low device select |
| sclk | output | 1 | Serial clock; devices capture on its rising edge |
| sdata | output | 1 | Serial data into chain position 0 |
| upd_n | output | 1 | Active-low commit strobe shared by the chain |

## Verification
The bench builds the block with three chained devices, SCLK_DIV of 4, STROBE_CYC of 3 and RST_HOLD of 5. With three devices there is a middle device whose frame must pass through one neighbour and be passed on to another, so a mistake in reverse-chain ordering or an off-by-one across a frame boundary changes at least two tables. A divider of 4 gives two-cycle clock halves, so it can be seen whether data changes in the wrong phase. Each table is distinct per device and per output, so a swapped group, bit or device shows up when the bench decodes the modelled shift registers.

// File: rtl/xpt_prog_pkg.sv
package xpt_prog_pkg;

  typedef enum logic [2:0] {
    ST_PWR,
    ST_IDLE,
    ST_SHIFT,
    ST_STROBE,
    ST_DONE
  } prog_state_t;

  // bits carried by the per-output groups of one frame
  function automatic int unsigned group_bits(int unsigned nout, int unsigned selw);
    return nout * (selw + 1);
  endfunction

  // full frame: clamp bit, output groups, zero padding
  function automatic int unsigned frame_bits(int unsigned nout, int unsigned selw,
                                             int unsigned pad);
    return 1 + group_bits(nout, selw) + pad;
  endfunction

  // counter width able to hold values 0..n-1
  function automatic int unsigned cnt_w(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // position of an address bit inside the packed source vector;
  // field position 1 is the MSB of the index
  function automatic int unsigned src_pos(int unsigned slot, int unsigned selw,
                                          int unsigned fpos);
    return slot * selw + (selw - fpos);
  endfunction

endpackage

// File: rtl/xpt_pwr_seq.sv
module xpt_pwr_seq #(
  parameter int unsigned RST_HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic pwr_ok
);
  import xpt_prog_pkg::*;

  localparam int unsigned CW = cnt_w(RST_HOLD + 1);

  logic [CW-1:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      pwr_ok   <= 1'b0;
    end else if (!pwr_ok) begin
      if (hold_cnt == CW'(RST_HOLD - 1)) pwr_ok <= 1'b1;
      else                               hold_cnt <= hold_cnt + CW'(1);
    end
  end

endmodule

// File: rtl/xpt_bit_seq.sv
module xpt_bit_seq #(
  parameter int unsigned NUM_DEV  = 2,
  parameter int unsigned NUM_OUT  = 16,
  parameter int unsigned SEL_W    = 5,
  parameter int unsigned PAD_BITS = 96,
  parameter int unsigned SCLK_DIV = 4,
  localparam int unsigned FRAME = xpt_prog_pkg::frame_bits(NUM_OUT, SEL_W, PAD_BITS),
  localparam int unsigned GRPB  = xpt_prog_pkg::group_bits(NUM_OUT, SEL_W),
  localparam int unsigned PH_W  = xpt_prog_pkg::cnt_w(SCLK_DIV),
  localparam int unsigned J_W   = xpt_prog_pkg::cnt_w(FRAME),
  localparam int unsigned G_W   = xpt_prog_pkg::cnt_w(NUM_OUT + 1),
  localparam int unsigned P_W   = xpt_prog_pkg::cnt_w(SEL_W + 1),
  localparam int unsigned DEV_W = xpt_prog_pkg::cnt_w(NUM_DEV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  output logic             sclk_hi,
  output logic             bit_tick,
  output logic             last_bit,
  output logic             is_clamp,
  output logic             in_grp,
  output logic [DEV_W-1:0] dev,
  output logic [G_W-1:0]   out_idx,
  output logic [P_W-1:0]   fpos
);

  localparam int unsigned HALF = SCLK_DIV / 2;

  logic [PH_W-1:0] ph;
  logic [J_W-1:0]  j;
  logic [G_W-1:0]  g;

  assign bit_tick = run && (ph == PH_W'(SCLK_DIV - 1));
  assign sclk_hi  = run && (ph >= PH_W'(HALF));
  assign last_bit = (dev == '0) && (j == J_W'(FRAME - 1));
  assign is_clamp = (j == '0);
  assign in_grp   = (j != '0) && (j <= J_W'(GRPB));
  assign out_idx  = G_W'(NUM_OUT - 1) - g;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= '0;
      j    <= '0;
      g    <= '0;
      fpos <= '0;
      dev  <= '0;
    end else if (load) begin
      ph   <= '0;
      j    <= '0;
      g    <= '0;
      fpos <= '0;
      dev  <= DEV_W'(NUM_DEV - 1);
    end else if (run) begin
      if (!bit_tick) begin
        ph <= ph + PH_W'(1);
      end else begin
        ph <= '0;
        if (!last_bit) begin
          if (j == J_W'(FRAME - 1)) begin
            j    <= '0;
            g    <= '0;
            fpos <= '0;
            dev  <= dev - DEV_W'(1);
          end else begin
            j <= j + J_W'(1);
            if (in_grp) begin
              if (fpos == P_W'(SEL_W)) begin
                fpos <= '0;
                g    <= g + G_W'(1);
              end else begin
                fpos <= fpos + P_W'(1);
              end
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/xpt_frame_mux.sv
module xpt_frame_mux #(
  parameter int unsigned NUM_DEV = 2,
  parameter int unsigned NUM_OUT = 16,
  parameter int unsigned SEL_W   = 5,
  parameter int unsigned DEV_W   = 1,
  parameter int unsigned G_W     = 5,
  parameter int unsigned P_W     = 3
) (
  input  logic [NUM_DEV*NUM_OUT*SEL_W-1:0] src_q,
  input  logic [NUM_DEV*NUM_OUT-1:0]       en_q,
  input  logic [NUM_DEV-1:0]               clamp_q,
  input  logic [DEV_W-1:0]                 dev,
  input  logic [G_W-1:0]                   out_idx,
  input  logic [P_W-1:0]                   fpos,
  input  logic                             is_clamp,
  input  logic                             in_grp,
  output logic                             bit_o
);
  import xpt_prog_pkg::*;

  int unsigned slot;

  always_comb begin
    slot  = int'(dev) * NUM_OUT + int'(out_idx);
    bit_o = 1'b0;
    if (is_clamp) begin
      bit_o = clamp_q[dev];
    end else if (in_grp) begin
      if (fpos == '0) bit_o = en_q[slot];
      else            bit_o = src_q[src_pos(slot, SEL_W, int'(fpos))];
    end
  end

endmodule

// File: rtl/xpt_chain_prog.sv
module xpt_chain_prog #(
  parameter int unsigned NUM_DEV    = 2,
  parameter int unsigned NUM_OUT    = 16,
  parameter int unsigned SEL_W      = 5,
  parameter int unsigned PAD_BITS   = 96,
  parameter int unsigned SCLK_DIV   = 4,
  parameter int unsigned STROBE_CYC = 2,
  parameter int unsigned RST_HOLD   = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic [NUM_DEV*NUM_OUT*SEL_W-1:0] cfg_src,
  input  logic [NUM_DEV*NUM_OUT-1:0]       cfg_en,
  input  logic [NUM_DEV-1:0]               cfg_clamp,
  output logic                             busy,
  output logic                             done,
  output logic                             dev_rst_n,
  output logic                             cs_n,
  output logic                             sclk,
  output logic                             sdata,
  output logic                             upd_n
);
  import xpt_prog_pkg::*;

  localparam int unsigned FRAME      = frame_bits(NUM_OUT, SEL_W, PAD_BITS);
  localparam int unsigned TOTAL_BITS = FRAME * NUM_DEV;
  localparam int unsigned G_W        = cnt_w(NUM_OUT + 1);
  localparam int unsigned P_W        = cnt_w(SEL_W + 1);
  localparam int unsigned DEV_W      = cnt_w(NUM_DEV);
  localparam int unsigned SC_W       = cnt_w(STROBE_CYC);

  prog_state_t state;
  logic [SC_W-1:0] str_cnt;
  logic [NUM_DEV*NUM_OUT*SEL_W-1:0] src_q;
  logic [NUM_DEV*NUM_OUT-1:0]       en_q;
  logic [NUM_DEV-1:0]               clamp_q;

  // named internal events
  logic pwr_ok, load, run, shift_end, strobe_last;
  logic sclk_hi, bit_tick, last_bit, is_clamp, in_grp, frame_bit;
  logic [DEV_W-1:0] dev;
  logic [G_W-1:0]   out_idx;
  logic [P_W-1:0]   fpos;

  assign load        = (state == ST_IDLE) && start;
  assign run         = (state == ST_SHIFT);
  assign shift_end   = bit_tick && last_bit;
  assign strobe_last = (state == ST_STROBE) && (str_cnt == '0);

  xpt_pwr_seq #(.RST_HOLD(RST_HOLD)) u_pwr (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok)
  );

  xpt_bit_seq #(
    .NUM_DEV(NUM_DEV), .NUM_OUT(NUM_OUT), .SEL_W(SEL_W),
    .PAD_BITS(PAD_BITS), .SCLK_DIV(SCLK_DIV)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .load(load), .run(run),
    .sclk_hi(sclk_hi), .bit_tick(bit_tick), .last_bit(last_bit),
    .is_clamp(is_clamp), .in_grp(in_grp), .dev(dev),
    .out_idx(out_idx), .fpos(fpos)
  );

  xpt_frame_mux #(
    .NUM_DEV(NUM_DEV), .NUM_OUT(NUM_OUT), .SEL_W(SEL_W),
    .DEV_W(DEV_W), .G_W(G_W), .P_W(P_W)
  ) u_mux (
    .src_q(src_q), .en_q(en_q), .clamp_q(clamp_q), .dev(dev),
    .out_idx(out_idx), .fpos(fpos), .is_clamp(is_clamp),
    .in_grp(in_grp), .bit_o(frame_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_PWR;
      str_cnt <= '0;
      src_q   <= '0;
      en_q    <= '0;
      clamp_q <= '0;
    end else begin
      unique case (state)
        ST_PWR:    if (pwr_ok) state <= ST_IDLE;
        ST_IDLE:   if (start) begin
                     state   <= ST_SHIFT;
                     src_q   <= cfg_src;
                     en_q    <= cfg_en;
                     clamp_q <= cfg_clamp;
                   end
        ST_SHIFT:  if (shift_end) begin
                     state   <= ST_STROBE;
                     str_cnt <= SC_W'(STROBE_CYC - 1);
                   end
        ST_STROBE: if (strobe_last) state <= ST_DONE;
                   else             str_cnt <= str_cnt - SC_W'(1);
        ST_DONE:   state <= ST_IDLE;
        default:   state <= ST_PWR;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);
  assign dev_rst_n = pwr_ok;
  assign cs_n      = !(run || (state == ST_STROBE));
  assign upd_n     = (state != ST_STROBE);
  assign sclk      = sclk_hi;
  assign sdata     = run && frame_bit;

endmodule

// File: rtl/xpt_chain_prog_chk.sv
module xpt_chain_prog_chk #(
  parameter int unsigned TOTAL_BITS = 386
) (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic sdata,
  input logic cs_n,
  input logic upd_n,
  input logic done,
  input logic busy,
  input logic dev_rst_n,
  input logic shift_end
);

  int unsigned edge_cnt;
  logic        sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_cnt <= 0;
      sclk_d   <= 1'b0;
    end else begin
      sclk_d <= sclk;
      if (cs_n)               edge_cnt <= 0;
      else if (sclk && !sclk_d) edge_cnt <= edge_cnt + 1;
    end
  end

  assert_quiet_in_powerup_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_rst_n |-> (upd_n && cs_n));

  assert_full_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(upd_n) |-> (edge_cnt == TOTAL_BITS));

  assert_data_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(sdata));

  assert_clock_selected_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);

  assert_commit_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(upd_n) |-> $past(shift_end));

  assert_commit_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_n |-> (!sclk && !cs_n));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (upd_n && cs_n && busy));

endmodule

bind xpt_chain_prog xpt_chain_prog_chk #(.TOTAL_BITS(TOTAL_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .cs_n(cs_n),
  .upd_n(upd_n), .done(done), .busy(busy), .dev_rst_n(dev_rst_n),
  .shift_end(shift_end)
);

// File: tb/test_xpt_chain_prog.sv
`timescale 1ns/1ps
module test_xpt_chain_prog;

  localparam int ND    = 3;
  localparam int NO    = 16;
  localparam int SW    = 5;
  localparam int PB    = 96;
  localparam int DIV   = 4;
  localparam int SC    = 3;
  localparam int RH    = 5;
  localparam int GRPB  = NO * (SW + 1);
  localparam int FRAME = 1 + GRPB + PB;
  localparam int TOTAL = FRAME * ND;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [ND*NO*SW-1:0] cfg_src = '0;
  logic [ND*NO-1:0]    cfg_en = '0;
  logic [ND-1:0]       cfg_clamp = '0;
  logic busy, done, dev_rst_n, cs_n, sclk, sdata, upd_n;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  xpt_chain_prog #(
    .NUM_DEV(ND), .NUM_OUT(NO), .SEL_W(SW), .PAD_BITS(PB),
    .SCLK_DIV(DIV), .STROBE_CYC(SC), .RST_HOLD(RH)
  ) i_xpt_chain_prog (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_src(cfg_src),
    .cfg_en(cfg_en), .cfg_clamp(cfg_clamp), .busy(busy), .done(done),
    .dev_rst_n(dev_rst_n), .cs_n(cs_n), .sclk(sclk), .sdata(sdata),
    .upd_n(upd_n)
  );

  // behavioural chain of device shift registers; newest bit at index 0
  logic [FRAME-1:0] dsr [ND];
  logic [FRAME-1:0] lat [ND];
  int edges = 0, edges_at_fall = 0;
  int upd_low = 0, sclk_high = 0, sd_viol = 0, cs_viol = 0, done_cnt = 0;
  logic prev_sd = 1'b0;

  always @(posedge sclk) begin
    if (!cs_n) begin
      for (int d = ND - 1; d > 0; d--) dsr[d] <= {dsr[d][FRAME-2:0], dsr[d-1][FRAME-1]};
      dsr[0] <= {dsr[0][FRAME-2:0], sdata};
      edges = edges + 1;
    end
  end

  always @(posedge upd_n) for (int d = 0; d < ND; d++) lat[d] = dsr[d];
  always @(negedge upd_n) edges_at_fall = edges;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!upd_n) upd_low++;
      if (sclk) sclk_high++;
      if (sclk && (sdata !== prev_sd)) sd_viol++;
      if (sclk && cs_n) cs_viol++;
      if (done) done_cnt++;
    end
    prev_sd = sdata;
  end

  int exp_src [ND][NO];
  bit exp_en  [ND][NO];
  bit exp_cl  [ND];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic make_table(input int mode);
    for (int d = 0; d < ND; d++) begin
      case (mode)
        0: exp_cl[d] = (d % 2 == 1);
        1: exp_cl[d] = 1'b1;
        2: exp_cl[d] = 1'b0;
        default: exp_cl[d] = (d % 2 == 0);
      endcase
      for (int o = 0; o < NO; o++) begin
        case (mode)
          0: begin exp_src[d][o] = (d * 11 + o * 3 + 1) % 32; exp_en[d][o] = ((d + o) % 3 != 0); end
          1: begin exp_src[d][o] = 31; exp_en[d][o] = 1'b1; end
          2: begin exp_src[d][o] = 0;  exp_en[d][o] = 1'b0; end
          default: begin exp_src[d][o] = (31 - o - 5 * d + 64) % 32; exp_en[d][o] = (o % 2 == 1); end
        endcase
      end
    end
    for (int d = 0; d < ND; d++) begin
      cfg_clamp[d] = exp_cl[d];
      for (int o = 0; o < NO; o++) begin
        cfg_src[(d*NO+o)*SW +: SW] = SW'(exp_src[d][o]);
        cfg_en[d*NO+o] = exp_en[d][o];
      end
    end
  endtask

  // R3/R4: decode each modelled device register against the table
  task automatic check_tables(input string tag);
    for (int d = 0; d < ND; d++) begin
      int bad = 0;
      logic [FRAME-1:0] f = lat[d];
      chk(f[FRAME-1] == exp_cl[d], {"R4 clamp bit first ", tag}, f[FRAME-1], exp_cl[d]);
      chk(f[PB-1:0] == '0, {"R4 zero padding ", tag}, $countones(f[PB-1:0]), 0);
      for (int o = 0; o < NO; o++) begin
        int base = 1 + (NO - 1 - o) * (SW + 1);
        int addr = 0;
        bit en = f[FRAME-1-base];
        for (int b = 0; b < SW; b++) addr = addr * 2 + int'(f[FRAME-1-(base+1+b)]);
        if (en != exp_en[d][o] || addr != exp_src[d][o]) bad++;
      end
      chk(bad == 0, {"R3 device table ", tag}, bad, 0);
    end
  endtask

  task automatic pulse_start;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic run_program(input string tag, input bit inject);
    int e0 = edges, u0 = upd_low, s0 = sclk_high, v0 = sd_viol, c0 = cs_viol, d0 = done_cnt;
    int t = 0;
    pulse_start();
    chk(!cs_n && busy, {"R6 select on first bit ", tag}, cs_n, 0);
    if (inject) begin
      repeat (200) @(negedge clk);
      cfg_src = ~cfg_src; cfg_en = ~cfg_en; cfg_clamp = ~cfg_clamp;
      pulse_start();
    end
    while (!done && t < 20000) begin @(negedge clk); t++; end
    chk(done == 1'b1, {"R8 done seen ", tag}, done, 1);
    chk(upd_n && cs_n, {"R8 done after strobe released ", tag}, {upd_n, cs_n}, 3);
    @(negedge clk);
    chk(!done && !busy, {"R8 single done then idle ", tag}, {done, busy}, 0);
    chk(edges - e0 == TOTAL, {"R2 rising edges ", tag}, edges - e0, TOTAL);
    chk(edges_at_fall - e0 == TOTAL, {"R7 strobe after last bit ", tag}, edges_at_fall - e0, TOTAL);
    chk(upd_low - u0 == SC, {"R7 strobe width ", tag}, upd_low - u0, SC);
    chk(sclk_high - s0 == TOTAL * (DIV / 2), {"R5 clock high time ", tag}, sclk_high - s0, TOTAL * (DIV / 2));
    chk(sd_viol == v0, {"R5 data steady while clock high ", tag}, sd_viol - v0, 0);
    chk(cs_viol == c0, {"R6 clock only while selected ", tag}, cs_viol - c0, 0);
    chk(done_cnt - d0 == 1, {"R9 one completion per request ", tag}, done_cnt - d0, 1);
    check_tables(tag);
  endtask

  task automatic test_powerup;
    int e0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!dev_rst_n && upd_n && cs_n && busy && !done && !sclk, "R1 reset state",
        {dev_rst_n, upd_n, cs_n, busy, done, sclk}, 6'b011100);
    e0 = edges;
    rst_n = 1'b1;
    start = 1'b1;
    for (int i = 1; i <= RH; i++) begin
      @(negedge clk);
      if (i == 2) start = 1'b0;
      if (i == RH - 1) chk(!dev_rst_n && upd_n && busy, "R1 held before release", dev_rst_n, 0);
      if (i == RH)     chk(dev_rst_n == 1'b1, "R1 release edge", dev_rst_n, 1);
    end
    @(negedge clk);
    chk(!busy && cs_n && upd_n, "R1 idle after power-up", busy, 0);
    chk(edges == e0, "R1 start ignored during power-up", edges - e0, 0);
  endtask

  initial begin
    test_powerup();
    make_table(0); run_program("distinct table", 1'b0);
    make_table(1); run_program("all max", 1'b0);
    make_table(2); run_program("all off", 1'b0);
    make_table(3); run_program("start while busy R9", 1'b1);
    make_table(0); run_program("back to back", 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule